// File: doc/BRIEF.md
# Dual-Threshold Over-Current Breaker Controller

This block decides when a supply switch must be opened because its load draws too much current, and when it may be closed again. It takes two digitised comparator flags. One says the load current is above the sustained limit. The other says it is above a much higher severe limit. The sustained flag passes through a selectable time filter, so short surges are tolerated. The severe flag, when enabled, opens the switch at once. The block drives a gate-off output to the switch and an active-low fault indication.

Restart behaviour depends on a mode input. In latched mode a fault stays until an operator pulse on the active-low breaker reset input. In auto-restart mode the switch closes again by itself after one cycle period. If the over-current is still present, it trips again. A breaker reset input held low keeps the switch open in either mode. After that input is released, an auto-restart waits one full cycle period counted from the release.

All time intervals are counted in ticks. A tick comes from the block clock through a parameterised prescaler, so the filter delays and the cycle period scale with one parameter. All inputs are assumed synchronous to `clk`.

Top module: `cbrk_ctrl`

## Requirements
- R1: After chip reset, `gate_off_o` is 0 and `fault_n_o` is 1.
- R2: `slow_sel_i` picks the filter delay D: 0 selects DLY0, 1 selects DLY1, 2 selects DLY2 and 3 selects DLY3. The breaker trips on the (D+1)-th consecutive tick on which `ovc_slow_i` is high. D consecutive high ticks do not trip it.
- R3: A single tick with `ovc_slow_i` low restarts the count of consecutive high ticks from zero.
- R4: With `fast_en_i` = 1, `ovc_fast_i` high for one cycle trips the breaker at the next clock edge. With `fast_en_i` = 0, `ovc_fast_i` is ignored.
- R5: At the edge where a trip is taken, `gate_off_o` goes to 1 and `fault_n_o` goes to 0 together.
- R6: With `auto_mode_i` = 0, a fault persists until `brk_rst_n_i` has been low for at least RST_MIN consecutive cycles and is then sampled high. The gate re-enables at that same edge.
- R7: With `auto_mode_i` = 1 and `brk_rst_n_i` high, the gate re-enables CYC_TICKS ticks after the trip edge. If the sustained over-current persists, the breaker trips again after the normal filter delay.
- R8: With `auto_mode_i` = 1, a fault stays while `brk_rst_n_i` is held low. The restart then happens CYC_TICKS ticks after the edge at which the release is sampled.
- R9: With no fault present, in either mode, `brk_rst_n_i` low for RST_MIN consecutive cycles sets `gate_off_o` at the RST_MIN-th edge and keeps it set while low. Both over-current flags are ignored during that time, `fault_n_o` stays 1, and the gate re-enables at the edge where the release is sampled.
- R10: A low pulse on `brk_rst_n_i` shorter than RST_MIN cycles has no effect.
- R11: `fault_n_o` returns to 1 at the same edge where `gate_off_o` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Chip reset, active low, asynchronous |
| ovc_slow_i | input | 1 | Current above sustained limit |
| ovc_fast_i | input | 1 | Current above severe limit |
| fast_en_i | input | 1 | 1 enables the instant severe trip |
| slow_sel_i | input | 2 | Filter delay select |
| auto_mode_i | input | 1 | 0 latched, 1 auto-restart |
| brk_rst_n_i | input | 1 | Breaker reset, active low |
| gate_off_o | output | 1 | 1 forces the supply switch off |
| fault_n_o | output | 1 | Over-current fault, active low |

## Verification
The bench builds the block with a prescaler of 1, so each clock cycle is one tick and every expected edge can be counted exactly. It uses filter delays of 3, 5, 8 and 12 ticks, a cycle period of 40 ticks and a reset qualification of 4 cycles. With these values the D versus D+1 filter boundary, a repeated auto-restart trip, a restart held off by the reset input, and the one-cycle-short reset pulse all fall within a few hundred cycles.

// File: rtl/cbrk_pkg.sv
package cbrk_pkg;

    typedef enum logic {
        CB_ARMED   = 1'b0,
        CB_TRIPPED = 1'b1
    } cb_state_e;

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/cbrk_rst_qual.sv
module cbrk_rst_qual #(
    parameter int unsigned RST_MIN = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic brk_rst_n_i,
    output logic held_o,
    output logic rel_o
);
    localparam int unsigned LW = $clog2(RST_MIN + 1) < 1 ? 1 : $clog2(RST_MIN + 1);
    localparam logic [LW-1:0] LOW_FULL = LW'(RST_MIN);
    localparam logic [LW-1:0] LOW_EDGE = LW'(RST_MIN - 1);

    typedef struct packed {
        logic [LW-1:0] low_cnt;
    } qual_t;

    qual_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (brk_rst_n_i) begin
            r_d.low_cnt = '0;
        end else if (r_q.low_cnt != LOW_FULL) begin
            r_d.low_cnt = r_q.low_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign held_o = !brk_rst_n_i && (r_q.low_cnt >= LOW_EDGE);
    assign rel_o  = brk_rst_n_i && (r_q.low_cnt == LOW_FULL);

    AST_REL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rel_o |=> !rel_o);                                          // R6
    AST_SHORT_NO_REL: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_rst_n_i && !held_o && !rel_o) |=> !rel_o);             // R10

endmodule

// File: rtl/cbrk_filter.sv
module cbrk_filter #(
    parameter int unsigned DLY0 = 5,
    parameter int unsigned DLY1 = 50,
    parameter int unsigned DLY2 = 150,
    parameter int unsigned DLY3 = 400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       armed_i,
    input  logic       flag_i,
    input  logic [1:0] sel_i,
    output logic       expired_o
);
    import cbrk_pkg::*;

    localparam int unsigned DMAX = max4(DLY0, DLY1, DLY2, DLY3);
    localparam int unsigned CW   = $clog2(DMAX + 1) < 1 ? 1 : $clog2(DMAX + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(DMAX);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } filt_t;

    filt_t r_q, r_d;
    logic [CW-1:0] limit;

    always_comb begin
        unique case (sel_i)
            2'd0:    limit = CW'(DLY0);
            2'd1:    limit = CW'(DLY1);
            2'd2:    limit = CW'(DLY2);
            default: limit = CW'(DLY3);
        endcase
    end

    always_comb begin
        r_d = r_q;
        if (!armed_i || !flag_i) begin
            r_d.cnt = '0;
        end else if (tick_i && r_q.cnt != CNT_TOP) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign expired_o = armed_i && flag_i && tick_i && (r_q.cnt >= limit);

    AST_GLITCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_i |=> !expired_o || (limit == '0));                   // R3

endmodule

// File: rtl/cbrk_ctrl.sv
module cbrk_ctrl #(
    parameter int unsigned PRESCALE  = 100,
    parameter int unsigned DLY0      = 5,
    parameter int unsigned DLY1      = 50,
    parameter int unsigned DLY2      = 150,
    parameter int unsigned DLY3      = 400,
    parameter int unsigned CYC_TICKS = 2_500_000,
    parameter int unsigned RST_MIN   = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ovc_slow_i,
    input  logic       ovc_fast_i,
    input  logic       fast_en_i,
    input  logic [1:0] slow_sel_i,
    input  logic       auto_mode_i,
    input  logic       brk_rst_n_i,
    output logic       gate_off_o,
    output logic       fault_n_o
);
    import cbrk_pkg::*;

    localparam int unsigned CYW = $clog2(CYC_TICKS + 1);
    localparam logic [CYW-1:0] CYC_LAST = CYW'(CYC_TICKS - 1);

    typedef struct packed {
        cb_state_e      st;
        logic           gate_off;
        logic           fault;
        logic [CYW-1:0] cyc;
    } ctl_t;

    ctl_t r_q, r_d;
    logic tick, held, rel, expired, armed, fast_hit;

    // Tick generator: a plain wire for a prescale of one, a counter otherwise
    generate
        if (PRESCALE <= 1) begin : g_no_prescale
            assign tick = 1'b1;
        end else begin : g_prescale
            localparam int unsigned PW = $clog2(PRESCALE);
            localparam logic [PW-1:0] PS_LAST = PW'(PRESCALE - 1);
            logic [PW-1:0] ps_q, ps_d;
            always_comb ps_d = (ps_q == PS_LAST) ? '0 : ps_q + 1'b1;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ps_q <= '0;
                else        ps_q <= ps_d;
            end
            assign tick = (ps_q == PS_LAST);
        end
    endgenerate

    cbrk_rst_qual #(.RST_MIN(RST_MIN)) u_qual (
        .clk         (clk),
        .rst_n       (rst_n),
        .brk_rst_n_i (brk_rst_n_i),
        .held_o      (held),
        .rel_o       (rel)
    );

    assign armed = (r_q.st == CB_ARMED) && !held;

    cbrk_filter #(.DLY0(DLY0), .DLY1(DLY1), .DLY2(DLY2), .DLY3(DLY3)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .armed_i   (armed),
        .flag_i    (ovc_slow_i),
        .sel_i     (slow_sel_i),
        .expired_o (expired)
    );

    assign fast_hit = fast_en_i && ovc_fast_i;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            CB_ARMED: begin
                if (held) begin
                    r_d.gate_off = 1'b1;
                end else if (fast_hit || expired) begin
                    r_d.st       = CB_TRIPPED;
                    r_d.gate_off = 1'b1;
                    r_d.fault    = 1'b1;
                    r_d.cyc      = '0;
                end else begin
                    r_d.gate_off = 1'b0;
                end
            end
            CB_TRIPPED: begin
                r_d.gate_off = 1'b1;
                r_d.fault    = 1'b1;
                if (!auto_mode_i) begin
                    if (rel) begin
                        r_d.st       = CB_ARMED;
                        r_d.gate_off = 1'b0;
                        r_d.fault    = 1'b0;
                    end
                end else if (held || rel) begin
                    r_d.cyc = '0;
                end else if (tick) begin
                    if (r_q.cyc == CYC_LAST) begin
                        r_d.st       = CB_ARMED;
                        r_d.gate_off = 1'b0;
                        r_d.fault    = 1'b0;
                        r_d.cyc      = '0;
                    end else begin
                        r_d.cyc = r_q.cyc + 1'b1;
                    end
                end
            end
            default: r_d = r_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= CB_ARMED;
            r_q.gate_off <= 1'b0;
            r_q.fault    <= 1'b0;
            r_q.cyc      <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign gate_off_o = r_q.gate_off;
    assign fault_n_o  = !r_q.fault;

    AST_FAULT_OPENS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n_o |-> gate_off_o);                                 // R5
    AST_QUICK_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == CB_ARMED && !held && fast_hit) |=> !fault_n_o);  // R4
    AST_HOLD_KEEPS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> gate_off_o);                                       // R9
    AST_LATCH_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_mode_i && !fault_n_o && !rel) |=> !fault_n_o);       // R6
    AST_CLEAR_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_n_o) |-> !gate_off_o);                          // R11
    AST_AUTO_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode_i && !fault_n_o && (held || rel)) |=> !fault_n_o); // R8

endmodule

// File: tb/cbrk_ctrl_test.sv
module cbrk_ctrl_test;

    localparam int unsigned CYC  = 40;
    localparam int unsigned RMIN = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ovc_slow_i, ovc_fast_i, fast_en_i, auto_mode_i, brk_rst_n_i;
    logic [1:0] slow_sel_i;
    logic       gate_off_o, fault_n_o;

    always #5 clk = ~clk;

    cbrk_ctrl #(
        .PRESCALE(1), .DLY0(3), .DLY1(5), .DLY2(8), .DLY3(12),
        .CYC_TICKS(CYC), .RST_MIN(RMIN)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ovc_slow_i(ovc_slow_i), .ovc_fast_i(ovc_fast_i),
        .fast_en_i(fast_en_i), .slow_sel_i(slow_sel_i), .auto_mode_i(auto_mode_i),
        .brk_rst_n_i(brk_rst_n_i), .gate_off_o(gate_off_o), .fault_n_o(fault_n_o)
    );

    typedef struct {
        logic  gate_off;
        logic  fault_n;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input logic g, input logic f, input string tag);
        exp_t e;
        e.gate_off = g;
        e.fault_n  = f;
        e.tag      = tag;
        exp_q.push_back(e);
    endtask

    task automatic clear_pulse();
        brk_rst_n_i = 1'b0;
        step(RMIN);
        brk_rst_n_i = 1'b1;
        step(1);
    endtask

    // Monitor: compares queued expectations away from the clock edge
    always @(negedge clk) begin
        #2;
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_vec++;
            if (gate_off_o !== e.gate_off || fault_n_o !== e.fault_n) begin
                n_bad++;
                $display("FAIL %s: gate_off/fault_n = %b/%b, expected %b/%b",
                         e.tag, gate_off_o, fault_n_o, e.gate_off, e.fault_n);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ovc_slow_i = 1'b0; ovc_fast_i = 1'b0; fast_en_i = 1'b1;
        slow_sel_i = 2'd0; auto_mode_i = 1'b0; brk_rst_n_i = 1'b1;
        step(3);
        rst_n = 1'b1;
        step(1);
        expect_out(1'b0, 1'b1, "R1 reset state");

        // Filter boundary, delay 3 (select 0), with a glitch in between
        ovc_slow_i = 1'b1; step(3);
        expect_out(1'b0, 1'b1, "R2 D high ticks no trip");
        ovc_slow_i = 1'b0; step(1);
        expect_out(1'b0, 1'b1, "R3 glitch low");
        ovc_slow_i = 1'b1; step(3);
        expect_out(1'b0, 1'b1, "R3 count restarted");
        step(1);
        expect_out(1'b1, 1'b0, "R2 R5 trip on D+1");
        ovc_slow_i = 1'b0;

        // Latched mode: stays, short pulse ignored, valid pulse clears
        step(CYC + 5);
        expect_out(1'b1, 1'b0, "R6 latched fault persists");
        brk_rst_n_i = 1'b0; step(RMIN - 1);
        brk_rst_n_i = 1'b1; step(3);
        expect_out(1'b1, 1'b0, "R10 short pulse ignored");
        brk_rst_n_i = 1'b0; step(RMIN);
        expect_out(1'b1, 1'b0, "R6 still off while low");
        brk_rst_n_i = 1'b1; step(1);
        expect_out(1'b0, 1'b1, "R6 R11 cleared on release");

        // Delay 12 (select 3)
        slow_sel_i = 2'd3;
        ovc_slow_i = 1'b1; step(12);
        expect_out(1'b0, 1'b1, "R2 select 3 no trip at D");
        step(1);
        expect_out(1'b1, 1'b0, "R2 select 3 trip");
        ovc_slow_i = 1'b0;
        clear_pulse();
        expect_out(1'b0, 1'b1, "R6 clear after select 3");

        // Quick trip
        fast_en_i = 1'b0; ovc_fast_i = 1'b1; step(5);
        expect_out(1'b0, 1'b1, "R4 quick trip disabled");
        fast_en_i = 1'b1; step(1);
        expect_out(1'b1, 1'b0, "R4 R5 quick trip");
        ovc_fast_i = 1'b0;
        clear_pulse();
        expect_out(1'b0, 1'b1, "R6 clear after quick trip");

        // Auto-restart with persistent over-current, delay 5
        auto_mode_i = 1'b1; slow_sel_i = 2'd1;
        ovc_slow_i = 1'b1; step(6);
        expect_out(1'b1, 1'b0, "R2 select 1 trip");
        step(CYC - 1);
        expect_out(1'b1, 1'b0, "R7 off until cycle ends");
        step(1);
        expect_out(1'b0, 1'b1, "R7 R11 auto restart");
        step(5);
        expect_out(1'b0, 1'b1, "R7 refiltered after restart");
        step(1);
        expect_out(1'b1, 1'b0, "R7 retrip");
        ovc_slow_i = 1'b0; step(CYC);
        expect_out(1'b0, 1'b1, "R7 second restart");

        // Auto mode with reset held low
        ovc_fast_i = 1'b1; step(1);
        expect_out(1'b1, 1'b0, "R4 quick trip auto mode");
        ovc_fast_i = 1'b0;
        brk_rst_n_i = 1'b0; step(CYC + 10);
        expect_out(1'b1, 1'b0, "R8 held low keeps off");
        brk_rst_n_i = 1'b1; step(CYC);
        expect_out(1'b1, 1'b0, "R8 full cycle after release");
        step(1);
        expect_out(1'b0, 1'b1, "R8 restart after release");

        // Hold without fault, auto mode then latched mode
        brk_rst_n_i = 1'b0; step(RMIN - 1);
        expect_out(1'b0, 1'b1, "R9 before qualification");
        step(1);
        expect_out(1'b1, 1'b1, "R9 gate off no fault");
        ovc_fast_i = 1'b1; ovc_slow_i = 1'b1; step(15);
        expect_out(1'b1, 1'b1, "R9 flags ignored while held");
        ovc_fast_i = 1'b0; ovc_slow_i = 1'b0;
        brk_rst_n_i = 1'b1; step(1);
        expect_out(1'b0, 1'b1, "R9 release auto mode");
        auto_mode_i = 1'b0;
        brk_rst_n_i = 1'b0; step(RMIN);
        expect_out(1'b1, 1'b1, "R9 held latched mode");
        brk_rst_n_i = 1'b1; step(1);
        expect_out(1'b0, 1'b1, "R9 release latched mode");

        step(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule